// File: doc/BRIEF.md
# Phase-Accumulator PWM Generator with Shadowed Configuration

This block produces one pulse-width-modulated output from a single 32-bit control word. Each enabled clock adds a programmable step value to an N-bit phase accumulator. Each carry out of the accumulator closes one output period, so the output frequency is the clock rate times step / 2^N. The duty cycle comes from an 8-bit divider, held in inverted form: the output is high while the top eight accumulator bits are above the divider. A larger divider therefore gives a shorter high time.

Software writes the step and divider into a shadow copy. These values reach the running generator only when software sets the update request bit. They are then copied into the active registers on the clock edge where the accumulator wraps, so a period is never cut short or stretched. The request bit clears itself on that same edge, and software polls it to learn when the change has landed. If the generator is disabled, or its active step is zero so that no wrap will ever come, a pending request is applied on the next clock instead.

Top module: `pwm_accum_ctrl`

## Requirements
- R1: After reset the control word reads as all zeros and the output is low.
- R2: Control word layout: bit 31 is output enable, bit 30 is the update request, bits [7:0] are the divider, and bits [8+STEP_W-1:8] are the step. A read returns enable, request status and the shadow step and divider. All other bits read as zero.
- R3: While enabled, each clock adds the active step to the N-bit accumulator modulo 2^N. Starting from accumulator zero, output cycle k (k = 0..2^N-1) sees the accumulator value (k*step) mod 2^N.
- R4: The output is high exactly when enabled, the active step is nonzero, and the top eight accumulator bits are strictly greater than the active divider. A divider of 255 keeps the output low for the whole period.
- R5: An active step of zero keeps the output constantly low, whatever the divider.
- R6: Writing step and divider with the request bit at 0 changes only the shadow copy, which readback shows. The running output keeps its old duty.
- R7: Writing 1 to the request bit makes it read 1 until the shadow values are copied to the active registers. While enabled with a nonzero active step, the copy and the clearing of the bit happen together on the clock edge where the accumulator carries out.
- R8: While disabled, or while the active step is zero, a pending request is applied and cleared on the next clock after it becomes pending.
- R9: While enable is 0 the accumulator is held at zero and the output is low. When enable rises, the next output cycle starts from accumulator zero.
- R10: Repeated requests carrying unchanged values each complete, and a later request with new values still takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word: enable, request status, shadow step and divider |
| pwm_out | output | 1 | PWM output |

## Verification
The bound checker checks on every cycle the following rules:
- the output is low while disabled, while the active step is zero, or while the divider is 255;
- the accumulator is at zero when enable rises;
- the active values change only on a cycle where a request was pending;
- a pending request clears one clock later while disabled.

Only the bench scenarios can show duty and period as counts over a full 2^N-cycle window. These scenarios sweep steps and dividers, check that shadow-only writes leave the duty alone, and check that redundant requests do not block a later real change.

// File: rtl/pwm_acc_pkg.sv
package pwm_acc_pkg;
    localparam int DIV_W     = 8;
    localparam int EN_BIT    = 31;
    localparam int UPD_BIT   = 30;
    localparam int FIELD_LSB = 8;
    localparam logic [DIV_W-1:0] DIV_MAX = '1;

    typedef logic [DIV_W-1:0] div_t;
endpackage

// File: rtl/pwm_acc_core.sv
module pwm_acc_core
    import pwm_acc_pkg::*;
#(
    parameter int ACC_W  = 10,
    parameter int STEP_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [STEP_W-1:0] step,
    input  div_t              div,
    output logic [ACC_W-1:0]  acc_q,
    output logic              wrap,
    output logic              pwm_out
);
    localparam int SUM_W = ACC_W + 1;

    logic [ACC_W-1:0] acc_d;
    logic [SUM_W-1:0] sum;
    div_t             phase_hi;

    always_comb begin
        sum      = {1'b0, acc_q} + SUM_W'(step);
        wrap     = en && sum[ACC_W];
        acc_d    = en ? sum[ACC_W-1:0] : '0;
        phase_hi = acc_q[ACC_W-1 -: DIV_W];
        pwm_out  = en && (step != '0) && (phase_hi > div);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end
endmodule

// File: rtl/pwm_acc_regs.sv
module pwm_acc_regs
    import pwm_acc_pkg::*;
#(
    parameter int STEP_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              wrap,
    output logic              en,
    output logic              upd,
    output logic [STEP_W-1:0] sh_step,
    output div_t              sh_div,
    output logic [STEP_W-1:0] act_step,
    output div_t              act_div
);
    localparam int HI_LSB = FIELD_LSB + STEP_W;

    typedef struct packed {
        logic              en;
        logic              upd;
        logic [STEP_W-1:0] sh_step;
        div_t              sh_div;
        logic [STEP_W-1:0] act_step;
        div_t              act_div;
    } cfg_t;

    cfg_t st_d, st_q;
    logic apply;
    logic unused_wr_hi;

    assign unused_wr_hi = ^wr_data[UPD_BIT-1:HI_LSB];

    always_comb begin
        st_d  = st_q;
        // a stalled or stopped generator has no wrap to wait for
        apply = st_q.upd && (!st_q.en || (st_q.act_step == '0) || wrap);
        if (apply) begin
            st_d.act_step = st_q.sh_step;
            st_d.act_div  = st_q.sh_div;
            st_d.upd      = 1'b0;
        end
        if (wr_en) begin
            st_d.en      = wr_data[EN_BIT];
            st_d.sh_step = wr_data[FIELD_LSB +: STEP_W];
            st_d.sh_div  = wr_data[DIV_W-1:0];
            if (wr_data[UPD_BIT]) st_d.upd = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en       = st_q.en;
    assign upd      = st_q.upd;
    assign sh_step  = st_q.sh_step;
    assign sh_div   = st_q.sh_div;
    assign act_step = st_q.act_step;
    assign act_div  = st_q.act_div;
endmodule

// File: rtl/pwm_accum_ctrl.sv
module pwm_accum_ctrl
    import pwm_acc_pkg::*;
#(
    parameter int ACC_W  = 10,
    parameter int STEP_W = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        pwm_out
);
    logic              en;
    logic              upd;
    logic              wrap;
    logic [STEP_W-1:0] sh_step;
    logic [STEP_W-1:0] act_step;
    div_t              sh_div;
    div_t              act_div;
    logic [ACC_W-1:0]  acc_q;

    pwm_acc_regs #(.STEP_W(STEP_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wrap(wrap), .en(en), .upd(upd), .sh_step(sh_step), .sh_div(sh_div),
        .act_step(act_step), .act_div(act_div)
    );

    pwm_acc_core #(.ACC_W(ACC_W), .STEP_W(STEP_W)) u_core (
        .clk(clk), .rst_n(rst_n), .en(en), .step(act_step), .div(act_div),
        .acc_q(acc_q), .wrap(wrap), .pwm_out(pwm_out)
    );

    always_comb begin
        rd_data                       = '0;
        rd_data[EN_BIT]               = en;
        rd_data[UPD_BIT]              = upd;
        rd_data[FIELD_LSB +: STEP_W]  = sh_step;
        rd_data[DIV_W-1:0]            = sh_div;
    end
endmodule

// File: rtl/pwm_accum_ctrl_chk.sv
module pwm_accum_ctrl_chk
    import pwm_acc_pkg::*;
#(
    parameter int ACC_W  = 10,
    parameter int STEP_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [31:0]       rd_data,
    input logic              pwm_out,
    input logic [STEP_W-1:0] act_step,
    input div_t              act_div,
    input logic [ACC_W-1:0]  acc_q
);
    p_div255_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (act_div == DIV_MAX) |-> !pwm_out);

    p_step0_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (act_step == '0) |-> !pwm_out);

    // R7: active values move only when a request was pending
    p_active_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(act_div) || !$stable(act_step)) |-> $past(rd_data[UPD_BIT]));

    p_disabled_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[EN_BIT] && rd_data[UPD_BIT] && !wr_en) |=> !rd_data[UPD_BIT]);

    p_off_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[EN_BIT] |-> !pwm_out);

    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[EN_BIT]) |-> (acc_q == '0));
endmodule

bind pwm_accum_ctrl pwm_accum_ctrl_chk #(.ACC_W(ACC_W), .STEP_W(STEP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_data(rd_data),
    .pwm_out(pwm_out), .act_step(act_step), .act_div(act_div), .acc_q(acc_q)
);

// File: tb/test_pwm_accum_ctrl.sv
module test_pwm_accum_ctrl;
    localparam int N    = 10;
    localparam int SPAN = 1 << N;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pwm_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    pwm_accum_ctrl #(.ACC_W(N), .STEP_W(N)) i_pwm_accum_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pwm_out(pwm_out)
    );

    function automatic logic [31:0] word(input bit e, input bit u, input int s, input int d);
        logic [31:0] w;
        w = '0;
        w[31] = e;
        w[30] = u;
        w[8 +: N] = s[N-1:0];
        w[7:0] = d[7:0];
        return w;
    endfunction

    // high cycles in a 2^N window starting from accumulator zero (R3, R4)
    function automatic int exp_high(input int s, input int d);
        int c;
        c = 0;
        for (int k = 0; k < SPAN; k++) begin
            if ((((k * s) % SPAN) >> (N - 8)) > d) c++;
        end
        return c;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive at negedge, return at the following negedge
    task automatic write(input logic [31:0] w);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic count_high(input int cycles, output int c);
        c = 0;
        for (int k = 0; k < cycles; k++) begin
            if (pwm_out) c++;
            @(negedge clk);
        end
    endtask

    task automatic wait_clear(input int limit, output int waited);
        waited = 0;
        while (rd_data[30] && waited < limit) begin
            @(negedge clk);
            waited++;
        end
    endtask

    initial begin
        int c, w;
        int steps [5] = '{1, 2, 64, 512, 1023};
        int divs  [5] = '{0, 1, 127, 254, 255};
        repeat (3) @(negedge clk);
        check(rd_data == 32'h0, "R1 reset word", rd_data, 0);
        check(pwm_out == 1'b0, "R1 reset output", pwm_out, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4 sweep of step and divider from accumulator zero
        foreach (steps[i]) begin
            foreach (divs[j]) begin
                write(word(0, 1, steps[i], divs[j]));
                @(negedge clk);
                check(rd_data[30] == 1'b0, "R8 disabled apply", rd_data[30], 0);
                write(word(1, 0, steps[i], divs[j]));
                count_high(SPAN, c);
                check(c == exp_high(steps[i], divs[j]), "R3 R4 high count", c, exp_high(steps[i], divs[j]));
                write(word(0, 0, steps[i], divs[j]));
            end
        end

        // R2 readback layout
        write(word(0, 0, 9'h155, 8'hA5));
        check(rd_data == 32'h0001_55A5, "R2 readback", rd_data, 32'h0001_55A5);

        // R9 disabled output low and restart from zero
        count_high(200, c);
        check(c == 0, "R9 disabled low", c, 0);
        write(word(0, 1, 3, 100));
        @(negedge clk);
        write(word(1, 0, 3, 100));
        count_high(SPAN, c);
        check(c == exp_high(3, 100), "R9 restart from zero", c, exp_high(3, 100));

        // R6 shadow-only write keeps old duty
        write(word(1, 0, 7, 10));
        check(rd_data == word(1, 0, 7, 10), "R6 shadow readback", rd_data, word(1, 0, 7, 10));
        count_high(SPAN, c);
        check(c == 4 * (255 - 100), "R6 old duty kept", c, 4 * (255 - 100));

        // R7 request pending then applied at wrap
        write(word(1, 1, 7, 10));
        check(rd_data[30] == 1'b1, "R7 pending reads 1", rd_data[30], 1);
        wait_clear(SPAN, w);
        check(w > 0 && w <= SPAN / 3 + 3, "R7 clears at next wrap", w, SPAN / 3);
        count_high(SPAN, c);
        check(c == 4 * (255 - 10), "R7 new duty", c, 4 * (255 - 10));

        // R10 redundant requests then a real change
        write(word(1, 1, 7, 10));
        wait_clear(SPAN, w);
        check(rd_data[30] == 1'b0, "R10 first redundant", rd_data[30], 0);
        write(word(1, 1, 7, 10));
        wait_clear(SPAN, w);
        check(rd_data[30] == 1'b0, "R10 second redundant", rd_data[30], 0);
        write(word(1, 1, 9, 200));
        wait_clear(SPAN, w);
        check(rd_data[30] == 1'b0, "R10 real change clears", rd_data[30], 0);
        count_high(SPAN, c);
        check(c == 4 * (255 - 200), "R10 real change applied", c, 4 * (255 - 200));

        // R8 request while disabled clears after one clock
        write(word(0, 1, 5, 50));
        check(rd_data[30] == 1'b1, "R8 pending after write", rd_data[30], 1);
        @(negedge clk);
        check(rd_data[30] == 1'b0, "R8 cleared next clock", rd_data[30], 0);
        write(word(1, 0, 5, 50));
        count_high(SPAN, c);
        check(c == exp_high(5, 50), "R8 applied values", c, exp_high(5, 50));

        // R5 zero step stays low, then a request applies on the next clock
        write(word(0, 1, 0, 0));
        @(negedge clk);
        write(word(1, 0, 0, 0));
        count_high(300, c);
        check(c == 0, "R5 zero step low", c, 0);
        write(word(1, 1, 3, 0));
        @(negedge clk);
        check(rd_data[30] == 1'b0, "R8 zero-step apply", rd_data[30], 0);
        count_high(SPAN, c);
        check(c == 4 * 255, "R5 resumes after step set", c, 4 * 255);

        done = 1'b1;
    end

    initial begin
        for (int t = 0; t < 150000; t++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule